// File: doc/BRIEF.md
# Two-Pass Subranging Converter Sequencer

This block is the digital controller of a 4-bit subranging analog-to-digital converter built from one bank of three comparators that is used twice. After a start request the block lets the input be held, then runs a coarse pass. In that pass the comparators see thresholds at one, two and three quarters of the reference, and the block turns their thermometer word into the two upper result bits. Those bits go out to a DAC, whose output is subtracted from the held input. The block then waits a set number of cycles for the DAC and the subtractor to settle. It switches the comparators to thresholds at one, two and three sixteenths of the reference and runs a fine pass on the residue, which gives the two lower bits.

A one-cycle done strobe marks the cycle in which the 4-bit result becomes valid. The result stays valid until the next conversion ends. The comparators, DAC and subtractor lie outside the block. Each pass length and the settle length are parameters. The comparator word is captured only on the final cycle of a pass, so any comparator settling that takes several cycles is absorbed by the pass length.

Top module: `subrange_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, done_o, result_o, dac_code_o, stage_sel_o and bubble_o are all zero.
- R2: With STAGE_CYCLES=S and SETTLE_CYCLES=W, done_o rises exactly 1+2S+W rising edges after the edge that captures start_i in the idle state.
- R3: stage_sel_o is 0 (quarter thresholds) during the coarse pass and 1 (sixteenth thresholds) from the end of the coarse pass through the settle wait and the fine pass. It returns to 0 when done_o rises.
- R4: At the end of the coarse pass, dac_code_o takes the coarse 2-bit code. It then stays unchanged through the settle wait, the fine pass and the done cycle.
- R5: result_o equals the coarse code in bits [3:2] and the fine code in bits [1:0]. For comparators that model an input of k sixteenths of the reference (0 to 15), it equals k.
- R6: A valid comparator word (ones filled from bit 0 upward) is encoded as its count of ones. Any other nonzero word is encoded as the index of its highest set bit plus one, and it sets bubble_o. bubble_o is cleared when a new start is accepted and gathers flags from both passes.
- R7: The comparator word is used only on the last cycle of each pass. Values present on earlier cycles of the pass have no effect on the result.
- R8: done_o is high for exactly one cycle. result_o changes only together with done_o and holds its value afterwards.
- R9: start_i is ignored while a conversion is in progress. A start pulse in the middle of a conversion changes neither its latency nor its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, accepted only in idle |
| comp_i | input | 3 | Comparator outputs, bit 0 = lowest threshold |
| stage_sel_o | output | 1 | Threshold set select: 0 coarse, 1 fine |
| dac_code_o | output | 2 | Coarse code driving the residue DAC |
| result_o | output | 4 | Converted value, coarse above fine |
| done_o | output | 1 | One-cycle strobe marking a new result |
| bubble_o | output | 1 | Comparator word of this conversion was not a valid thermometer |

## Verification
On every cycle, the assertions check the shape of the done strobe and that the result changes only with it. They also check that the DAC code changes only at the end of a coarse pass, that the fine pass is entered only from the settle wait, and that the threshold select is low in idle. The exact latency, the code each threshold set produces, the bubble encoding and the immunity to comparator glitches before the last cycle of a pass are shown only by the bench. The bench drives behavioural comparators across all sixteen input levels, forces bubble words in each pass and pulses start in the middle of a conversion.

// File: rtl/subrange_pkg.sv
package subrange_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SAMPLE,
    PH_COARSE,
    PH_SETTLE,
    PH_FINE,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/therm_enc.sv
module therm_enc #(
  parameter int CODE_W = 2,
  localparam int COMPS = (1 << CODE_W) - 1
) (
  input  logic [COMPS-1:0]  word_i,
  output logic [CODE_W-1:0] code_o,
  output logic              bubble_o
);
  logic [COMPS-1:0] word_inc;

  always_comb begin
    code_o = '0;
    for (int i = 0; i < COMPS; i++) begin
      if (word_i[i]) code_o = CODE_W'(i + 1);
    end
  end

  assign word_inc = word_i + 1'b1;
  assign bubble_o = (word_i & word_inc) != '0;

  always_comb begin
    if (!bubble_o) begin
      assert_code_matches_count_R6: assert (code_o == CODE_W'($countones(word_i)));
    end
  end
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int MAX_LEN = 4,
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load_i) begin
      remain <= len_i - 1'b1;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign last_o = (remain == '0);

  assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |-> (len_i != '0));
endmodule

// File: rtl/subrange_seq.sv
module subrange_seq
  import subrange_pkg::*;
#(
  parameter int STAGE_BITS    = 2,
  parameter int STAGE_CYCLES  = 2,
  parameter int SETTLE_CYCLES = 3,
  localparam int COMPS    = (1 << STAGE_BITS) - 1,
  localparam int RES_W    = 2 * STAGE_BITS,
  localparam int MAX_LEN  = (STAGE_CYCLES > SETTLE_CYCLES) ? STAGE_CYCLES : SETTLE_CYCLES,
  localparam int CNT_W    = $clog2(MAX_LEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [COMPS-1:0]      comp_i,
  output logic                  stage_sel_o,
  output logic [STAGE_BITS-1:0] dac_code_o,
  output logic [RES_W-1:0]      result_o,
  output logic                  done_o,
  output logic                  bubble_o
);
  phase_t                phase;
  logic                  pass_last;
  logic                  tmr_load;
  logic [CNT_W-1:0]      tmr_len;
  logic [STAGE_BITS-1:0] enc_code;
  logic                  enc_bubble;

  therm_enc #(.CODE_W(STAGE_BITS)) u_enc (
    .word_i   (comp_i),
    .code_o   (enc_code),
    .bubble_o (enc_bubble)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_len  = CNT_W'(STAGE_CYCLES);
    case (phase)
      PH_SAMPLE: tmr_load = 1'b1;
      PH_COARSE: begin
        tmr_load = pass_last;
        tmr_len  = CNT_W'(SETTLE_CYCLES);
      end
      PH_SETTLE: tmr_load = pass_last;
      default:   tmr_load = 1'b0;
    endcase
  end

  phase_timer #(.MAX_LEN(MAX_LEN)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .last_o (pass_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      stage_sel_o <= 1'b0;
      dac_code_o  <= '0;
      result_o    <= '0;
      done_o      <= 1'b0;
      bubble_o    <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start_i) begin
            phase    <= PH_SAMPLE;
            bubble_o <= 1'b0;
          end
        end
        PH_SAMPLE: phase <= PH_COARSE;
        PH_COARSE: begin
          if (pass_last) begin
            dac_code_o  <= enc_code;
            bubble_o    <= enc_bubble;
            stage_sel_o <= 1'b1;
            phase       <= PH_SETTLE;
          end
        end
        PH_SETTLE: begin
          if (pass_last) phase <= PH_FINE;
        end
        PH_FINE: begin
          if (pass_last) begin
            result_o    <= {dac_code_o, enc_code};
            bubble_o    <= bubble_o | enc_bubble;
            done_o      <= 1'b1;
            stage_sel_o <= 1'b0;
            phase       <= PH_DONE;
          end
        end
        PH_DONE: begin
          done_o <= 1'b0;
          phase  <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_result_moves_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_o) |-> done_o);

  assert_dac_held_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code_o) |-> ($past(phase) == PH_COARSE));

  assert_fine_after_settle_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FINE && $past(phase) != PH_FINE) |-> ($past(phase) == PH_SETTLE));

  assert_idle_coarse_select_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE || phase == PH_COARSE) |-> !stage_sel_o);
endmodule

// File: tb/sim_subrange_seq.sv
`timescale 1ns/1ps
module sim_subrange_seq;
  localparam int S = 2;
  localparam int W = 3;
  localparam int LAT = 2 + 2 * S + W;  // count including the start edge

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [2:0] comp_i;
  logic       stage_sel_o;
  logic [1:0] dac_code_o;
  logic [3:0] result_o;
  logic       done_o;
  logic       bubble_o;

  int total = 0;
  int bad = 0;

  int         vin = 0;
  logic       glitch = 1'b0;
  logic       ovr_c_en = 1'b0;
  logic [2:0] ovr_c = '0;
  logic       ovr_f_en = 1'b0;
  logic [2:0] ovr_f = '0;

  always #2 clk = ~clk;

  subrange_seq #(.STAGE_BITS(2), .STAGE_CYCLES(S), .SETTLE_CYCLES(W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .comp_i(comp_i),
    .stage_sel_o(stage_sel_o), .dac_code_o(dac_code_o), .result_o(result_o),
    .done_o(done_o), .bubble_o(bubble_o)
  );

  // behavioural comparators: coarse thresholds 4,8,12 /16; fine 1,2,3 /16 on residue
  always_comb begin
    logic [2:0] w;
    int res;
    res = vin - 4 * int'(dac_code_o);
    for (int k = 0; k < 3; k++) begin
      if (!stage_sel_o) w[k] = (vin >= 4 * (k + 1));
      else              w[k] = (res >= (k + 1));
    end
    if (!stage_sel_o && ovr_c_en) w = ovr_c;
    if (stage_sel_o && ovr_f_en)  w = ovr_f;
    comp_i = glitch ? ~w : w;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic convert(input int v, input int exp_res, input int exp_dac,
                         input logic exp_bub, input logic mid_start);
    int n;
    logic [3:0] held;
    vin = v;
    n = 0;
    @(negedge clk);
    start_i = 1'b1;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start_i = (mid_start && n == 4);
      if (n == 2) begin
        check(stage_sel_o == 1'b0, "R3 coarse select", stage_sel_o, 0);
        glitch = 1'b1;  // R7: first coarse cycle garbage
      end
      if (n == 3) glitch = 1'b0;
      if (n == 4) begin
        check(stage_sel_o == 1'b1, "R3 fine select in settle", stage_sel_o, 1);
        check(dac_code_o == 2'(exp_dac), "R4 dac code after coarse", dac_code_o, exp_dac);
      end
      if (n == 7) glitch = 1'b1;  // R7: first fine cycle garbage
      if (n == 8) glitch = 1'b0;
      if (done_o || n > 40) break;
    end
    start_i = 1'b0;
    check(n == LAT, "R2/R9 latency", n, LAT);
    check(result_o == 4'(exp_res), "R5/R7 result", result_o, exp_res);
    check(bubble_o == exp_bub, "R6 bubble flag", bubble_o, exp_bub);
    check(dac_code_o == 2'(exp_dac), "R4 dac held to done", dac_code_o, exp_dac);
    check(stage_sel_o == 1'b0, "R3 select back at done", stage_sel_o, 0);
    held = result_o;
    @(negedge clk);
    check(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    check(result_o == held, "R8 result held", result_o, held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({done_o, result_o, dac_code_o, stage_sel_o, bubble_o} == '0, "R1 in reset",
          {done_o, result_o, dac_code_o, stage_sel_o, bubble_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({done_o, result_o, dac_code_o, stage_sel_o, bubble_o} == '0, "R1 after reset",
          {done_o, result_o, dac_code_o, stage_sel_o, bubble_o}, 0);

    // R5: sweep every input level with valid thermometer words
    for (int v = 0; v < 16; v++) convert(v, v, v / 4, 1'b0, 1'b0);

    // R9: start pulse in the middle of a conversion
    convert(10, 10, 2, 1'b0, 1'b1);
    // R9: idle stays idle afterwards
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R9 no extra conversion", done_o, 0);

    // R6: coarse bubble 101 -> highest bit = code 3, input 13
    ovr_c_en = 1'b1; ovr_c = 3'b101;
    convert(13, 13, 3, 1'b1, 1'b0);
    // R6: coarse bubble 010 -> code 2, input 9
    ovr_c = 3'b010;
    convert(9, 9, 2, 1'b1, 1'b0);
    ovr_c_en = 1'b0;
    // R6: fine bubble 010 -> code 2, input 6
    ovr_f_en = 1'b1; ovr_f = 3'b010;
    convert(6, 6, 1, 1'b1, 1'b0);
    ovr_f_en = 1'b0;
    // R6: flag cleared on next start
    convert(5, 5, 1, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule